// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Page Mode and Refresh

This block sits between a simple host request port and a 64K x 1 asynchronous DRAM whose cells form a 256 x 256 array. A host request carries a 16-bit bit address, a read/write flag and one write bit. The controller splits the address into a row half and a column half and drives both, one after the other, on one shared 8-bit address bus. The row half is strobed with the row strobe and the column half with the column strobe. It also drives the write-enable line and the data-in bit, and it samples the data-out bit.

Opening a row copies the whole row into the device's column latches and leaves the cells empty, so the row strobe must stay asserted until the row has been written back. The controller keeps the row open after an access. A following request to the same row then needs only a column strobe, which is page mode. A request to another row first closes the page with a write-back phase. A free-running interval timer asks for one refresh row at a time. At the next access boundary that request takes priority: the open page is closed, and a row-strobe-only cycle runs on the row named by a wrapping 8-bit counter.

All phase lengths are parameters counted in clock cycles.

Top module: `dram_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the row strobe, column strobe and write-enable (all active low) are high, `rdata_valid` is low and `req_ready` is high.
- R2: For every access, the bus value when the row strobe falls equals address bits [15:8]. The bus value when the column strobe falls equals address bits [7:0]. The bus is held stable while the row strobe is asserted in the row phase.
- R3: A write puts `req_wdata` on `dram_din` with write-enable low when the column strobe falls. A read returns on `rdata` the `dram_dout` value of the addressed bit.
- R4: A read accepted with no row open gives `rdata_valid` exactly T_RAS+T_CAS clock edges after the accepting edge (6 by default).
- R5: A read accepted while its row is open (page hit) issues a column strobe with no new row strobe. It gives `rdata_valid` T_CAS edges after acceptance (1 by default).
- R6: A read to a different row while a page is open first holds the row strobe high for T_RW cycles and then opens the new row. It gives `rdata_valid` T_RW+T_RAS+T_CAS edges after acceptance (9 by default).
- R7: The column strobe is never low while the row strobe is high. Successive falling edges of the column strobe are at least T_PC cycles apart.
- R8: Every REF_INTERVAL cycles a refresh runs as a row-strobe-only cycle, with the column strobe held high. Its row comes from a counter that starts at 0 after reset, increments by 1 per refresh and wraps modulo 256. When the controller is idle, the falling edges of successive refresh row strobes are exactly REF_INTERVAL cycles apart.
- R9: A pending refresh holds `req_ready` low and starts only with the row closed. If a page is open, it is closed first, so the next access to that row is again a full row cycle.
- R10: `req_ready` is low from the edge after acceptance until the access finishes. `rdata_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Bit address: [15:8] row, [7:0] column |
| req_wdata | input | 1 | Bit to write |
| rdata | output | 1 | Read result |
| rdata_valid | output | 1 | One-cycle pulse marking `rdata` |
| dram_addr | output | 8 | Multiplexed row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | 1 | Data bit to the device |
| dram_dout | input | 1 | Data bit from the device |

## Verification
Read data is due a fixed number of edges after the accepting edge: 6 from a closed row, 1 on a page hit and 9 on a page miss. The bench counts clock edges from acceptance and samples `rdata_valid` at falling edges, so each count lands on the edge that the register chain predicts. A behavioural device model latches row and column on the strobe edges, sampling at falling clock edges, and returns data within the same cycle the column strobe falls. The controller samples that data on the last column edge. Refresh timing is checked by stamping refresh row-strobe falls in cycle numbers during an idle stretch and comparing their spacing with the interval. The latency tests start just after a refresh, so no refresh can fall inside them.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,    // row closed, waiting
    S_ROW,     // row strobe low, row address on bus
    S_COL,     // column strobe low
    S_CGAP,    // column strobe high, completes page cycle
    S_OPEN,    // row open, waiting for a page hit
    S_PRE,     // row strobe high, write-back before next row
    S_REF,     // row-strobe-only refresh
    S_REFPRE   // write-back after refresh
  } seq_state_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int INTERVAL = 390
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end

  // a new interval must never arrive while the previous refresh still waits
  AST_NO_LOST_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (!pend || ack)); // R8

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctrl_pkg::*;
#(
  parameter int HALF  = 8,
  parameter int T_RAS = 5,
  parameter int T_CAS = 1,
  parameter int T_RW  = 3,
  parameter int T_PC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2*HALF-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rdata,
  output logic              rdata_valid,
  input  logic              ref_pend,
  output logic              ref_ack,
  output logic [HALF-1:0]   dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_din,
  input  logic              dram_dout
);
  localparam int T_GAP = (T_PC > T_CAS) ? (T_PC - T_CAS) : 1;
  localparam int TMAX  = max4(T_RAS, T_CAS, T_RW, T_GAP);
  localparam int CW    = $clog2(TMAX + 1);

  function automatic logic [HALF-1:0] row_of(input logic [2*HALF-1:0] a);
    return a[2*HALF-1:HALF];
  endfunction

  function automatic logic [HALF-1:0] col_of(input logic [2*HALF-1:0] a);
    return a[HALF-1:0];
  endfunction

  seq_state_e      st;
  logic [CW-1:0]   cnt;
  logic [HALF-1:0] cur_row, cur_col, ref_row;
  logic            cur_we, cur_d, miss_wait;

  // named internal events
  logic accept, page_hit, phase_done;
  assign accept     = req_valid && req_ready;
  assign page_hit   = (row_of(req_addr) == cur_row);
  assign phase_done = (cnt == '0);
  assign ref_ack    = (st == S_IDLE) && ref_pend;

  assign req_ready  = ((st == S_IDLE) || (st == S_OPEN)) && !ref_pend;
  assign dram_ras_n = !((st == S_ROW) || (st == S_COL) || (st == S_CGAP) ||
                        (st == S_OPEN) || (st == S_REF));
  assign dram_cas_n = (st != S_COL);
  assign dram_we_n  = !((st == S_COL) && cur_we);
  assign dram_din   = cur_d;
  assign dram_addr  = (st == S_REF) ? ref_row : ((st == S_COL) ? cur_col : cur_row);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      cur_row     <= '0;
      cur_col     <= '0;
      ref_row     <= '0;
      cur_we      <= 1'b0;
      cur_d       <= 1'b0;
      miss_wait   <= 1'b0;
      rdata       <= 1'b0;
      rdata_valid <= 1'b0;
    end else begin
      rdata_valid <= 1'b0;
      if (accept) begin
        cur_row <= row_of(req_addr);
        cur_col <= col_of(req_addr);
        cur_we  <= req_write;
        cur_d   <= req_wdata;
      end
      case (st)
        S_IDLE: begin
          if (ref_pend) begin
            st  <= S_REF;
            cnt <= CW'(T_RAS - 1);
          end else if (accept) begin
            st  <= S_ROW;
            cnt <= CW'(T_RAS - 1);
          end
        end
        S_ROW: begin
          if (phase_done) begin
            st  <= S_COL;
            cnt <= CW'(T_CAS - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_COL: begin
          if (phase_done) begin
            if (!cur_we) begin
              rdata       <= dram_dout;
              rdata_valid <= 1'b1;
            end
            st  <= S_CGAP;
            cnt <= CW'(T_GAP - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_CGAP: begin
          if (phase_done) st <= S_OPEN;
          else cnt <= cnt - 1'b1;
        end
        S_OPEN: begin
          if (ref_pend) begin
            st        <= S_PRE;
            cnt       <= CW'(T_RW - 1);
            miss_wait <= 1'b0;
          end else if (accept) begin
            if (page_hit) begin
              st  <= S_COL;
              cnt <= CW'(T_CAS - 1);
            end else begin
              st        <= S_PRE;
              cnt       <= CW'(T_RW - 1);
              miss_wait <= 1'b1;
            end
          end
        end
        S_PRE: begin
          if (phase_done) begin
            if (miss_wait) begin
              st        <= S_ROW;
              cnt       <= CW'(T_RAS - 1);
              miss_wait <= 1'b0;
            end else st <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        S_REF: begin
          if (phase_done) begin
            st      <= S_REFPRE;
            cnt     <= CW'(T_RW - 1);
            ref_row <= ref_row + 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        S_REFPRE: begin
          if (phase_done) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n); // R7
  AST_ROW_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ROW && $past(st) == S_ROW) |-> $stable(dram_addr)); // R2
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |=> !rdata_valid); // R10
  AST_REF_BLOCKS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !req_ready); // R9
  AST_REF_FROM_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |-> dram_ras_n); // R9
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R10

endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int ADDR_W       = 16,
  parameter int T_RAS        = 5,
  parameter int T_CAS        = 1,
  parameter int T_RW         = 3,
  parameter int T_PC         = 3,
  parameter int REF_INTERVAL = 390
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_wdata,
  output logic                rdata,
  output logic                rdata_valid,
  output logic [ADDR_W/2-1:0] dram_addr,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic                dram_din,
  input  logic                dram_dout
);
  localparam int HALF = ADDR_W / 2;

  logic ref_pend, ref_ack;

  dram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .ack  (ref_ack),
    .pend (ref_pend)
  );

  dram_seq #(
    .HALF (HALF),
    .T_RAS(T_RAS),
    .T_CAS(T_CAS),
    .T_RW (T_RW),
    .T_PC (T_PC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rdata      (rdata),
    .rdata_valid(rdata_valid),
    .ref_pend   (ref_pend),
    .ref_ack    (ref_ack),
    .dram_addr  (dram_addr),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .dram_din   (dram_din),
    .dram_dout  (dram_dout)
  );

endmodule

// File: tb/tb_dram_ctrl.sv
module tb_dram_ctrl;
  localparam int T_RAS = 5, T_CAS = 1, T_RW = 3, T_PC = 3, REF_INT = 390;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready, rdata, rdata_valid;
  logic [7:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_din;
  logic        dram_dout = 1'b0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  dram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rdata(rdata), .rdata_valid(rdata_valid), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_din(dram_din), .dram_dout(dram_dout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- device model, sampled at falling clock edges ----------
  bit       mem [int];
  logic     p_ras = 1'b1, p_cas = 1'b1;
  logic [7:0] m_row = '0, m_col = '0;
  bit       cas_in_row = 0;
  int       ras_falls = 0, cas_falls = 0, last_cas = -100;
  int       cas_bad = 0, space_bad = 0;
  int       ref_cnt = 0, ref_row_exp = 0, ref_fall_cyc = 0, prev_ref_fall = -1;
  int       ras_fall_cyc = 0, ref_gap_last = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !dram_ras_n) begin
        m_row = dram_addr; cas_in_row = 0; ras_falls++; ras_fall_cyc = cyc;
      end
      if (p_cas && !dram_cas_n) begin
        if (dram_ras_n) cas_bad++;
        if (cyc - last_cas < T_PC) space_bad++;
        last_cas = cyc;
        m_col = dram_addr; cas_in_row = 1; cas_falls++;
        if (!dram_we_n) mem[{m_row, m_col}] = dram_din;
        dram_dout = mem.exists({m_row, m_col}) ? mem[{m_row, m_col}] : 1'b0;
      end
      if (!p_ras && dram_ras_n && !cas_in_row) begin
        // R8: row-strobe-only cycle uses the wrapping refresh counter
        check(m_row == ref_row_exp[7:0], "R8 refresh row", m_row, ref_row_exp[7:0]);
        ref_row_exp = (ref_row_exp + 1) % 256;
        prev_ref_fall = ref_fall_cyc;
        ref_fall_cyc = ras_fall_cyc;
        ref_gap_last = ref_fall_cyc - prev_ref_fall;
        ref_cnt++;
      end
    end
    p_ras = dram_ras_n;
    p_cas = dram_cas_n;
  end

  // ---------------- host access ----------------
  int  lat_q;
  bit  rd_q;
  int  row_seen, col_seen;

  task automatic access(input bit we, input logic [15:0] a, input bit d);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R10 ready low when busy", req_ready, 0);
    lat_q = 0;
    if (!we) begin
      while (!rdata_valid && lat_q < 100) begin
        lat_q++;
        @(negedge clk);
      end
      rd_q = rdata;
      @(negedge clk);
      check(!rdata_valid, "R10 single-cycle valid", rdata_valid, 0);
    end
    while (!req_ready) @(negedge clk);
    row_seen = m_row; col_seen = m_col;
  endtask

  // stimulus table: {write, data, address}
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b1, 16'h00FF},
    {1'b1, 1'b1, 16'hFF00},
    {1'b1, 1'b0, 16'hFF01},
    {1'b1, 1'b1, 16'h1234},
    {1'b0, 1'b0, 16'h00FF},
    {1'b0, 1'b0, 16'hFF00},
    {1'b0, 1'b0, 16'hFF01},
    {1'b0, 1'b0, 16'h1234},
    {1'b1, 1'b0, 16'h00FF},
    {1'b0, 1'b0, 16'h00FF}
  };

  bit shadow [int];

  task automatic wait_refresh();
    int c0;
    c0 = ref_cnt;
    while (ref_cnt == c0) @(negedge clk);
  endtask

  initial begin
    int rf0, cf0, rc0;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle in reset",
          {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    check(!rdata_valid, "R1 no valid in reset", rdata_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", req_ready, 1);
    check(dram_ras_n && dram_cas_n, "R1 strobes idle after reset",
          {dram_ras_n, dram_cas_n}, 3);

    // table walk: R2 address halves, R3 data path
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][17], VEC[i][15:0], VEC[i][16]);
      check(row_seen == VEC[i][15:8], "R2 row half", row_seen, VEC[i][15:8]);
      check(col_seen == VEC[i][7:0], "R2 column half", col_seen, VEC[i][7:0]);
      if (VEC[i][17]) shadow[VEC[i][15:0]] = VEC[i][16];
      else check(rd_q == shadow[VEC[i][15:0]], "R3 read data", rd_q, shadow[VEC[i][15:0]]);
    end

    // latency directed tests, started right after a refresh (row closed)
    wait_refresh();
    access(1'b1, 16'h1207, 1'b1); shadow[16'h1207] = 1'b1;
    wait_refresh();
    rf0 = ras_falls;
    access(1'b0, 16'h1207, 1'b0);
    check(lat_q == T_RAS + T_CAS, "R4 closed-row latency", lat_q, T_RAS + T_CAS);
    check(rd_q == 1'b1, "R3 read after write", rd_q, 1);
    check(ras_falls == rf0 + 1, "R4 one row strobe", ras_falls - rf0, 1);
    rf0 = ras_falls; cf0 = cas_falls;
    access(1'b0, 16'h12A0, 1'b0);
    check(lat_q == T_CAS, "R5 page-hit latency", lat_q, T_CAS);
    check(ras_falls == rf0, "R5 no new row strobe", ras_falls - rf0, 0);
    check(cas_falls == cf0 + 1, "R5 one column strobe", cas_falls - cf0, 1);
    access(1'b1, 16'h12A1, 1'b1); shadow[16'h12A1] = 1'b1;
    access(1'b0, 16'h12A1, 1'b0);
    check(rd_q == 1'b1, "R5 page write then read", rd_q, 1);
    rf0 = ras_falls;
    access(1'b0, 16'h3401, 1'b0);
    check(lat_q == T_RW + T_RAS + T_CAS, "R6 page-miss latency", lat_q, T_RW + T_RAS + T_CAS);
    check(ras_falls == rf0 + 1, "R6 new row opened", ras_falls - rf0, 1);
    check(row_seen == 8'h34, "R6 new row address", row_seen, 8'h34);

    // R9: open page, let refresh take over, then access is a full row cycle
    access(1'b0, 16'h5500, 1'b0);
    wait_refresh();
    access(1'b0, 16'h5501, 1'b0);
    check(lat_q == T_RAS + T_CAS, "R9 page closed by refresh", lat_q, T_RAS + T_CAS);

    // R8: idle spacing of refresh cycles
    wait_refresh();
    rc0 = ref_cnt;
    repeat (3 * REF_INT + 20) @(negedge clk);
    check(ref_cnt - rc0 >= 3, "R8 refresh count while idle", ref_cnt - rc0, 3);
    check(ref_gap_last == REF_INT, "R8 idle refresh interval", ref_gap_last, REF_INT);

    // R7 strobe ordering and page spacing over the whole run
    check(cas_bad == 0, "R7 column strobe under row strobe", cas_bad, 0);
    check(space_bad == 0, "R7 column strobe spacing", space_bad, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog (all) act=%0d exp=0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule